// File: doc/BRIEF.md
# Two-Step Lookahead First-Order Recursive Filter

This block is a single-pole recursive smoothing filter whose ideal behaviour is y(n) = x(n) + A·y(n-1). The recurrence has been expanded by one step so that each output depends on y(n-2) through the squared coefficient, plus a feed-forward correction A·x(n-1). Because the feedback path then spans two sample registers, the multiplier and the adder in the loop sit in separate register stages. The loop still accepts one new sample every clock cycle.

The coefficient is a signed fixed-point elaboration parameter with 14 fractional bits. Its square is rounded to the same format when the design is elaborated, so the loop uses a constant multiplier and never computes A·A at run time. Samples enter with a valid strobe. Cycles without the strobe leave the filter history untouched. Results leave through a fixed two-register latency, clamped to the signed range of the output width.

Top module: `iir_lookahead`

## Requirements
- R1: For each accepted sample, the internal result is y(n) = x(n) + floor(A·x(n-1)/2^14) + floor(A2·y(n-2)/2^14). Here A2 = floor((A·A + 2^13)/2^14), and the arithmetic is two's complement with DATA_W + GUARD_W bits.
- R2: While reset is asserted, and on the first cycle after it, out_valid is 0 and out_data is 0.
- R3: out_valid equals in_valid delayed by exactly two clock cycles. Each output belongs to the input accepted two cycles earlier.
- R4: A cycle with in_valid low does not advance x(n-1), y(n-1) or y(n-2). In that cycle out_data keeps its previous value.
- R5: out_data is the internal result clamped to [-2^(DATA_W-1), 2^(DATA_W-1)-1]. With the default DATA_W of 16 this is [-32768, 32767].
- R6: With A = 12288 (0.75), a unit impulse of 16384 followed by zeros gives exactly 16384, 12288, 9216, 6912, 5184, 3888, 2916, 2187.
- R7: With A = 0.75 and no clamping, every output stays within 6 LSB of the exact real-valued recurrence y(n) = x(n) + 0.75·y(n-1).
- R8: After reset, x(n-1), y(n-1) and y(n-2) are zero, including when reset arrives with samples still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_data as a new sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks out_data as a new result |
| out_data | output | DATA_W | Signed, clamped filter output |

## Verification
The hardest case to reach is a sample whose y(n-2) term comes from a result produced several cycles back, across a gap of invalid cycles. This tests whether the in-loop product register stalls together with the history registers. The stimulus interleaves valid and idle cycles at random and compares every output against an independent model of the expanded recurrence. A second model of the plain one-step recurrence, in real arithmetic, bounds the rounding drift. A reset issued while two samples are still in the pipeline, followed by the impulse table, shows that the history was cleared. Long runs of full-scale input drive the internal sum well beyond the output range so that both clamp limits are reached.

// File: rtl/iir_la_pkg.sv
package iir_la_pkg;

    // Cycles from an accepted input to its output strobe
    localparam int LA_LATENCY = 2;

    // Square of a fixed-point coefficient, rounded half up to the same format
    function automatic int coef_square(input int c, input int frac);
        return (c * c + (1 << (frac - 1))) >>> frac;
    endfunction

    // Largest positive value of a signed word of the given width
    function automatic int signed_max(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/la_input_reg.sv
module la_input_reg #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vld_i,
    input  logic signed [W-1:0] dat_i,
    output logic                vld_o,
    output logic signed [W-1:0] dat_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            dat_o <= '0;
        end else begin
            vld_o <= vld_i;
            dat_o <= dat_i;
        end
    end

endmodule

// File: rtl/la_cmul.sv
module la_cmul #(
    parameter int ACC_W  = 20,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 14,
    parameter int COEF   = 12288
) (
    input  logic signed [ACC_W-1:0] a,
    output logic signed [ACC_W-1:0] p
);

    localparam int PW = ACC_W + COEF_W;
    localparam logic signed [COEF_W-1:0] K = COEF_W'(COEF);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] k_ext;
    logic signed [PW-1:0] full;

    always_comb begin
        a_ext = {{COEF_W{a[ACC_W-1]}}, a};
        k_ext = {{ACC_W{K[COEF_W-1]}}, K};
        full  = a_ext * k_ext;
        p     = ACC_W'(full >>> FRAC_W);
    end

endmodule

// File: rtl/la_loop.sv
module la_loop #(
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 20,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 14,
    parameter int COEF    = 12288,
    parameter int COEF_SQ = 9216
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [ACC_W-1:0]  y_now
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] x_prev;
    logic signed [ACC_W-1:0] y_prev;
    logic signed [ACC_W-1:0] fb_term;
    logic signed [ACC_W-1:0] ff_prod;
    logic signed [ACC_W-1:0] fb_prod;

    assign x_ext = {{EXT_W{x[DATA_W-1]}}, x};

    // Feed-forward correction A*x(n-1)
    la_cmul #(
        .ACC_W (ACC_W),
        .COEF_W(COEF_W),
        .FRAC_W(FRAC_W),
        .COEF  (COEF)
    ) u_ff_mul (
        .a(x_prev),
        .p(ff_prod)
    );

    // Loop product A^2*y(n-1), registered so it is used one sample later
    la_cmul #(
        .ACC_W (ACC_W),
        .COEF_W(COEF_W),
        .FRAC_W(FRAC_W),
        .COEF  (COEF_SQ)
    ) u_fb_mul (
        .a(y_prev),
        .p(fb_prod)
    );

    assign y_now = x_ext + ff_prod + fb_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_prev  <= '0;
            y_prev  <= '0;
            fb_term <= '0;
        end else if (vld) begin
            x_prev  <= x_ext;
            y_prev  <= y_now;
            fb_term <= fb_prod;
        end
    end

endmodule

// File: rtl/la_sat_out.sv
module la_sat_out #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld,
    input  logic signed [ACC_W-1:0]  y,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam logic signed [ACC_W-1:0] HI = ACC_W'(iir_la_pkg::signed_max(DATA_W));
    localparam logic signed [ACC_W-1:0] LO = -HI - 1;

    logic signed [DATA_W-1:0] sat;

    always_comb begin
        if (y > HI)
            sat = HI[DATA_W-1:0];
        else if (y < LO)
            sat = LO[DATA_W-1:0];
        else
            sat = y[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= vld;
            if (vld)
                out_data <= sat;
        end
    end

endmodule

// File: rtl/iir_lookahead.sv
module iir_lookahead #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 14,
    parameter int GUARD_W = 4,
    parameter int COEF   = 12288
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int ACC_W   = DATA_W + GUARD_W;
    localparam int COEF_SQ = iir_la_pkg::coef_square(COEF, FRAC_W);

    logic                     stg_vld;
    logic signed [DATA_W-1:0] stg_x;
    logic signed [ACC_W-1:0]  loop_y;

    la_input_reg #(
        .W(DATA_W)
    ) u_in (
        .clk  (clk),
        .rst  (rst),
        .vld_i(in_valid),
        .dat_i(in_data),
        .vld_o(stg_vld),
        .dat_o(stg_x)
    );

    la_loop #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W),
        .COEF   (COEF),
        .COEF_SQ(COEF_SQ)
    ) u_loop (
        .clk  (clk),
        .rst  (rst),
        .vld  (stg_vld),
        .x    (stg_x),
        .y_now(loop_y)
    );

    la_sat_out #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .vld      (stg_vld),
        .y        (loop_y),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: rtl/iir_lookahead_chk.sv
module iir_lookahead_chk #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     stg_vld,
    input logic signed [ACC_W-1:0]  loop_y,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data
);

    localparam logic signed [ACC_W-1:0]  HI_A = ACC_W'(iir_la_pkg::signed_max(DATA_W));
    localparam logic signed [ACC_W-1:0]  LO_A = -HI_A - 1;
    localparam logic signed [DATA_W-1:0] HI_D = HI_A[DATA_W-1:0];
    localparam logic signed [DATA_W-1:0] LO_D = LO_A[DATA_W-1:0];

    // R2: first cycle after reset shows the cleared output
    a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    // R3: strobe delay of two cycles once reset is two cycles behind
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R4: output holds when no new result is produced
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !out_valid) |-> $stable(out_data));

    // R5: upper clamp
    a_r5_clamp_hi: assert property (@(posedge clk) disable iff (rst)
        (stg_vld && loop_y > HI_A) |=> (out_data == HI_D));

    // R5: lower clamp
    a_r5_clamp_lo: assert property (@(posedge clk) disable iff (rst)
        (stg_vld && loop_y < LO_A) |=> (out_data == LO_D));

endmodule

bind iir_lookahead iir_lookahead_chk #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .stg_vld  (stg_vld),
    .loop_y   (loop_y),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/test_iir_lookahead.sv
module test_iir_lookahead;

    localparam int  DW   = 16;
    localparam int  FR   = 14;
    localparam int  A    = 12288;
    localparam int  A2   = (A * A + (1 << (FR - 1))) >>> FR;
    localparam int  HI   = 32767;
    localparam int  LO   = -32768;
    localparam int  NTAB = 8;
    localparam int TAB_X [NTAB] = '{16384, 0, 0, 0, 0, 0, 0, 0};
    localparam int TAB_Y [NTAB] = '{16384, 12288, 9216, 6912, 5184, 3888, 2916, 2187};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model of the expanded recurrence
    longint m_xp, m_yp, m_fb;
    real    r_prev;
    bit     real_chk = 1'b0;
    int     last_out = 0;

    int    exp_q[$];
    int    cyc_q[$];
    string tag_q[$];

    iir_lookahead i_iir_lookahead (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_xp = 0; m_yp = 0; m_fb = 0; r_prev = 0.0;
    endtask

    // returns clamped expected output
    function automatic int model_step(input int x);
        longint y, fbn;
        y   = longint'(x) + ((longint'(A) * m_xp) >>> FR) + m_fb;
        fbn = (longint'(A2) * m_yp) >>> FR;
        m_fb = fbn;
        m_xp = x;
        m_yp = y;
        if (y > HI) return HI;
        if (y < LO) return LO;
        return int'(y);
    endfunction

    task automatic send(input int x, input bit v, input string tag, input bit use_tab, input int tab);
        int e;
        real r, d;
        @(negedge clk);
        in_valid = v;
        in_data  = DW'(x);
        if (v) begin
            e = model_step(x);
            r = real'(x) + (real'(A) / 16384.0) * r_prev;
            r_prev = r;
            if (real_chk) begin
                d = real'(e) - r;
                if (d < 0.0) d = -d;
                check(d <= 6.0, "R7 drift vs ideal recurrence", e, int'(r));
            end
            exp_q.push_back(use_tab ? tab : e);
            cyc_q.push_back(cyc);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send(0, 1'b0, "", 1'b0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        exp_q.delete(); cyc_q.delete(); tag_q.delete();
        model_clear();
        last_out = 0;
        repeat (3) @(negedge clk);
        check(!out_valid, "R2 out_valid in reset", int'(out_valid), 0);
        check(out_data == 0, "R2 out_data in reset", int'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R2 out_valid after reset", int'(out_valid), 0);
        check(out_data == 0, "R2 out_data after reset", int'(out_data), 0);
    endtask

    // output monitor: R1/R3/R4/R5 by queue, latency by cycle count
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected out_valid", 1, 0);
                end else begin
                    int e, c;
                    string t;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_data) == e, t, int'(out_data), e);
                    check(cyc - c == 2, "R3 latency", cyc - c, 2);
                end
                last_out = int'(out_data);
            end else begin
                check(int'(out_data) == last_out, "R4 hold when idle", int'(out_data), last_out);
            end
        end
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();

        // R6: impulse table walked by one loop, expected from the table
        for (int i = 0; i < NTAB; i++)
            send(TAB_X[i], 1'b1, "R6 impulse response", 1'b1, TAB_Y[i]);
        idle(4);

        // R1/R4/R7: random samples with random idle gaps
        real_chk = 1'b1;
        for (int i = 0; i < 300; i++) begin
            int x;
            bit v;
            x = int'($urandom_range(8000)) - 4000;
            v = ($urandom_range(9) < 6);
            send(x, v, "R1 lookahead recurrence with gaps", 1'b0, 0);
        end
        idle(4);
        real_chk = 1'b0;

        // R1: back-to-back alternating signs
        for (int i = 0; i < 40; i++)
            send((i % 2 == 0) ? 3000 : -2500, 1'b1, "R1 alternating input", 1'b0, 0);
        idle(4);

        // R5: drive the sum past both limits
        for (int i = 0; i < 60; i++)
            send(HI, 1'b1, "R5 upper clamp", 1'b0, 0);
        for (int i = 0; i < 80; i++)
            send(LO, 1'b1, "R5 lower clamp", 1'b0, 0);
        idle(4);

        // R8: reset with samples in flight, then the impulse again
        send(20000, 1'b1, "", 1'b0, 0);
        send(-15000, 1'b1, "", 1'b0, 0);
        do_reset();
        for (int i = 0; i < NTAB; i++)
            send(TAB_X[i], 1'b1, "R8 impulse after mid-stream reset", 1'b1, TAB_Y[i]);
        idle(5);

        check(exp_q.size() == 0, "R3 missing outputs", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule